// File: doc/BRIEF.md
# Physical Memory Access Permission Checker

This block decides whether a single memory access may proceed. A request carries a byte address, a size in bytes, the read/write/execute rights it needs and whether it comes from machine mode or a lower privilege level. Alongside the request the block sees the current protection state: one configuration byte per entry, one address register per entry, and two security flags. The security flags are a lockdown flag and an allow-list-only flag.

Each entry decodes its own byte range. The entries are scanned from the lowest index up, and the first enabled entry that touches the access settles the outcome. That outcome is full coverage, which selects a permission set, or coverage of only one end of the access, which denies it outright. When no entry covers the access, a fallback policy driven by the security flags applies. The resulting permission set and a grant flag are registered, so they appear one clock after the request strobe.

Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 range mode (0 disabled, 1 top-of-range, 2 four-byte aligned, 3 power-of-two aligned), bit 7 lock. Bits 6:5 are not used. Permission vectors on the ports are {X,W,R}.

Top module: `pmp_access_checker`

## Requirements
- R1: Mode 1 (top-of-range) covers byte addresses from 4×(previous entry's register) up to 4×(own register)−1. Entry 0 uses 0 as its lower bound. When the lower bound is at or above 4×(own register), the entry covers nothing.
- R2: Mode 2 covers the four bytes starting at 4×(register).
- R3: Mode 3 forms t = 4×register+3. Its start is t AND (t+1) and its inclusive end is t OR (t+1), so each trailing one in the register doubles the region above its 8-byte minimum.
- R4: Entries are examined in rising index order and entries in mode 0 are skipped. The lowest-index entry that covers the access decides, even when a later entry also covers it.
- R5: If the deciding entry covers exactly one of the first and last byte of the access, the access is denied with an empty permission set.
- R6: With lockdown clear, a machine-mode access matching an unlocked entry gets {X,W,R}=7. Every other matching access gets the entry's bits 2:0.
- R7: With lockdown set, a machine-mode match uses index {L,R,W,X} (L=bit 7). Indexes 2, 3 and 14 give RW. Indexes 9 and 10 give X. Indexes 11 and 13 give RX. Indexes 12 and 15 give R. All other indexes give nothing.
- R8: With lockdown set, a lower-mode match uses the same index. Indexes 1, 10 and 11 give X. Indexes 2, 4 and 15 give R. Indexes 3 and 6 give RW. Index 5 gives RX, index 7 gives RWX, and all other indexes give nothing.
- R9: On a full match, grant is 1 exactly when every requested bit is in the permission set.
- R10: With no covering entry, the fallback applies in this order. With the allow-list flag set, the request is denied with set 0. Otherwise, with lockdown set, machine-mode requests without execute are granted with set 3 and all others are denied with set 0. Otherwise machine mode is granted with set 7 and lower modes are denied with set 0.
- R11: The last byte of the access is address+size−1, and a size of 0 counts as 4 bytes.
- R12: The response valid flag, permission set and grant appear one cycle after a request strobe. Without a strobe, the permission set and grant keep their values and the valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | PA_W | Byte address of first accessed byte |
| req_size | input | SIZE_W | Access size in bytes, 0 means 4 |
| req_perm | input | 3 | Requested rights {X,W,R} |
| req_mmode | input | 1 | 1 for machine mode, 0 for lower modes |
| cfg_bytes | input | 8*N | Entry configuration bytes, entry i at bits 8i+7:8i |
| addr_regs | input | N*(PA_W-2) | Entry address registers (byte address divided by 4) |
| sec_lockdown | input | 1 | Lockdown flag |
| sec_allowlist | input | 1 | Allow-list-only flag |
| resp_valid | output | 1 | Response valid |
| resp_allow | output | 3 | Granted permission set {X,W,R} |
| resp_grant | output | 1 | Access granted |

## Verification
The bench targets accesses that straddle a region edge by one byte. A design that only tested the first byte would grant these, where the correct result is a denial. It also places an earlier narrow entry under a wider later one: a design with reversed priority would hand out the wider entry's rights. Top-of-range entries with a zero or inverted bound check that an empty region matches nothing, and sweeps through all sixteen lockdown table indexes in both modes catch any swapped row. Size-zero requests confirm the four-byte default, which would otherwise shrink the access to one byte and miss the partial-overlap case.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } match_e;

  localparam int CFG_R    = 0;
  localparam int CFG_W    = 1;
  localparam int CFG_X    = 2;
  localparam int CFG_LOCK = 7;

  localparam logic [2:0] PERM_NONE = 3'b000;
  localparam logic [2:0] PERM_R    = 3'b001;
  localparam logic [2:0] PERM_RW   = 3'b011;
  localparam logic [2:0] PERM_X    = 3'b100;
  localparam logic [2:0] PERM_RX   = 3'b101;
  localparam logic [2:0] PERM_RWX  = 3'b111;

  // lockdown table, machine-mode row; idx = {L,R,W,X}
  function automatic logic [2:0] lockdown_mach(input logic [3:0] idx);
    logic [2:0] res;
    case (idx)
      4'd2, 4'd3, 4'd14: res = PERM_RW;
      4'd9, 4'd10:       res = PERM_X;
      4'd11, 4'd13:      res = PERM_RX;
      4'd12, 4'd15:      res = PERM_R;
      default:           res = PERM_NONE;
    endcase
    return res;
  endfunction

  // lockdown table, lower-mode row
  function automatic logic [2:0] lockdown_user(input logic [3:0] idx);
    logic [2:0] res;
    case (idx)
      4'd1, 4'd10, 4'd11: res = PERM_X;
      4'd2, 4'd4, 4'd15:  res = PERM_R;
      4'd3, 4'd6:         res = PERM_RW;
      4'd5:               res = PERM_RX;
      4'd7:               res = PERM_RWX;
      default:            res = PERM_NONE;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match #(
  parameter int PA_W = 34
) (
  input  logic [7:0]      cfg,
  input  logic [PA_W-3:0] own_reg,
  input  logic [PA_W-3:0] prev_reg,
  input  logic [PA_W:0]   first_byte,
  input  logic [PA_W:0]   last_byte,
  output logic            enabled,
  output logic            hit_first,
  output logic            hit_last
);
  import pmp_chk_pkg::*;

  localparam int EXT_W = PA_W + 1;

  match_e            mode;
  logic [PA_W-1:0]   t_val;
  logic [PA_W-1:0]   t_inc;
  logic [EXT_W-1:0]  lo_b;   // inclusive start
  logic [EXT_W-1:0]  hi_b;   // exclusive end

  assign mode  = match_e'(cfg[4:3]);
  assign t_val = {own_reg, 2'b11};
  assign t_inc = t_val + 1'b1;

  always_comb begin
    lo_b = '0;
    hi_b = '0;
    case (mode)
      MATCH_TOR: begin
        lo_b = {1'b0, prev_reg, 2'b00};
        hi_b = {1'b0, own_reg, 2'b00};
      end
      MATCH_NA4: begin
        lo_b = {1'b0, own_reg, 2'b00};
        hi_b = {1'b0, own_reg, 2'b00} + EXT_W'(4);
      end
      MATCH_NAPOT: begin
        lo_b = {1'b0, t_val & t_inc};
        hi_b = {1'b0, t_val | t_inc} + EXT_W'(1);
      end
      default: begin
        lo_b = '0;
        hi_b = '0;
      end
    endcase
  end

  assign enabled   = (mode != MATCH_OFF);
  // an inverted top-of-range bound leaves lo_b >= hi_b: nothing hits
  assign hit_first = enabled && (first_byte >= lo_b) && (first_byte < hi_b);
  assign hit_last  = enabled && (last_byte  >= lo_b) && (last_byte  < hi_b);

endmodule

// File: rtl/pmp_prio_scan.sv
module pmp_prio_scan #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     enabled,
  input  logic [N-1:0]     hit_first,
  input  logic [N-1:0]     hit_last,
  output logic             found,
  output logic             partial,
  output logic [IDX_W-1:0] sel_idx
);
  logic [N-1:0] touch;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_touch
      assign touch[gi] = enabled[gi] && (hit_first[gi] || hit_last[gi]);
    end
  endgenerate

  // walk downward so the lowest touching index is the last written
  always_comb begin
    found   = 1'b0;
    partial = 1'b0;
    sel_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (touch[i]) begin
        found   = 1'b1;
        partial = hit_first[i] ^ hit_last[i];
        sel_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval (
  input  logic       found,
  input  logic       partial,
  input  logic [7:0] sel_cfg,
  input  logic       mmode,
  input  logic       lockdown,
  input  logic       allowlist,
  input  logic [2:0] want,
  output logic [2:0] allow,
  output logic       grant
);
  import pmp_chk_pkg::*;

  logic [3:0] tbl_idx;
  assign tbl_idx = {sel_cfg[CFG_LOCK], sel_cfg[CFG_R], sel_cfg[CFG_W], sel_cfg[CFG_X]};

  always_comb begin
    allow = PERM_NONE;
    grant = 1'b0;
    if (found && partial) begin
      allow = PERM_NONE;
      grant = 1'b0;
    end else if (found) begin
      if (!lockdown) begin
        if (mmode && !sel_cfg[CFG_LOCK]) allow = PERM_RWX;
        else                             allow = sel_cfg[2:0];
      end else if (mmode) begin
        allow = lockdown_mach(tbl_idx);
      end else begin
        allow = lockdown_user(tbl_idx);
      end
      grant = ((want & ~allow) == 3'b000);
    end else if (allowlist) begin
      allow = PERM_NONE;
      grant = 1'b0;
    end else if (lockdown) begin
      if (mmode && !want[CFG_X]) begin
        allow = PERM_RW;
        grant = 1'b1;
      end
    end else if (mmode) begin
      allow = PERM_RWX;
      grant = 1'b1;
    end
  end

endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker #(
  parameter int N      = 8,
  parameter int PA_W   = 34,
  parameter int SIZE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [PA_W-1:0]       req_addr,
  input  logic [SIZE_W-1:0]     req_size,
  input  logic [2:0]            req_perm,
  input  logic                  req_mmode,
  input  logic [8*N-1:0]        cfg_bytes,
  input  logic [N*(PA_W-2)-1:0] addr_regs,
  input  logic                  sec_lockdown,
  input  logic                  sec_allowlist,
  output logic                  resp_valid,
  output logic [2:0]            resp_allow,
  output logic                  resp_grant
);
  localparam int REG_W = PA_W - 2;
  localparam int EXT_W = PA_W + 1;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [EXT_W-1:0] first_b;
  logic [EXT_W-1:0] last_b;
  logic [EXT_W-1:0] span;
  logic [N-1:0]     en_v, hf_v, hl_v;
  logic             found, partial;
  logic [IDX_W-1:0] sel_idx;
  logic [7:0]       sel_cfg;
  logic [2:0]       allow_c;
  logic             grant_c;

  assign first_b = {1'b0, req_addr};
  assign span    = (req_size == '0) ? EXT_W'(4) : EXT_W'(req_size);
  assign last_b  = first_b + span - EXT_W'(1);

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_ent
      logic [REG_W-1:0] prev_r;
      if (gi == 0) begin : g_first
        assign prev_r = '0;
      end else begin : g_rest
        assign prev_r = addr_regs[(gi-1)*REG_W +: REG_W];
      end
      pmp_region_match #(.PA_W(PA_W)) u_match (
        .cfg        (cfg_bytes[gi*8 +: 8]),
        .own_reg    (addr_regs[gi*REG_W +: REG_W]),
        .prev_reg   (prev_r),
        .first_byte (first_b),
        .last_byte  (last_b),
        .enabled    (en_v[gi]),
        .hit_first  (hf_v[gi]),
        .hit_last   (hl_v[gi])
      );
    end
  endgenerate

  pmp_prio_scan #(.N(N)) u_scan (
    .enabled   (en_v),
    .hit_first (hf_v),
    .hit_last  (hl_v),
    .found     (found),
    .partial   (partial),
    .sel_idx   (sel_idx)
  );

  assign sel_cfg = cfg_bytes[sel_idx*8 +: 8];

  pmp_perm_eval u_eval (
    .found     (found),
    .partial   (partial),
    .sel_cfg   (sel_cfg),
    .mmode     (req_mmode),
    .lockdown  (sec_lockdown),
    .allowlist (sec_allowlist),
    .want      (req_perm),
    .allow     (allow_c),
    .grant     (grant_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_allow <= 3'b000;
      resp_grant <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_allow <= allow_c;
        resp_grant <= grant_c;
      end
    end
  end

endmodule

// File: rtl/pmp_access_checker_sva.sv
module pmp_access_checker_sva #(
  parameter int N      = 8,
  parameter int PA_W   = 34,
  parameter int SIZE_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic [2:0]            req_perm,
  input logic                  req_mmode,
  input logic [8*N-1:0]        cfg_bytes,
  input logic                  sec_lockdown,
  input logic                  sec_allowlist,
  input logic                  resp_valid,
  input logic [2:0]            resp_allow,
  input logic                  resp_grant
);
  logic none_on;
  always_comb begin
    none_on = 1'b1;
    for (int i = 0; i < N; i++)
      if (cfg_bytes[i*8+3 +: 2] != 2'b00) none_on = 1'b0;
  end

  p_valid_follows_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  p_idle_no_valid_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!resp_valid && $stable(resp_allow) && $stable(resp_grant)));
  p_grant_subset_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_perm != 3'b000) |=> (!resp_grant || (($past(req_perm) & ~resp_allow) == 3'b000)));
  p_allowlist_deny_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && none_on && sec_allowlist) |=> (!resp_grant && resp_allow == 3'b000));
  p_lockdown_default_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && none_on && !sec_allowlist && sec_lockdown)
      |=> (resp_grant == ($past(req_mmode) && !$past(req_perm[2]))));
  p_classic_default_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && none_on && !sec_allowlist && !sec_lockdown)
      |=> (resp_grant == $past(req_mmode)));

endmodule

bind pmp_access_checker pmp_access_checker_sva #(.N(N), .PA_W(PA_W), .SIZE_W(SIZE_W)) u_sva (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_perm      (req_perm),
  .req_mmode     (req_mmode),
  .cfg_bytes     (cfg_bytes),
  .sec_lockdown  (sec_lockdown),
  .sec_allowlist (sec_allowlist),
  .resp_valid    (resp_valid),
  .resp_allow    (resp_allow),
  .resp_grant    (resp_grant)
);

// File: tb/pmp_access_checker_tb.sv
module pmp_access_checker_tb;
  localparam int N = 8;
  localparam int PA_W = 34;
  localparam int SIZE_W = 4;
  localparam int REG_W = PA_W - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [PA_W-1:0] req_addr = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic [2:0] req_perm = '0;
  logic req_mmode = 1'b0;
  logic [8*N-1:0] cfg_bytes;
  logic [N*REG_W-1:0] addr_regs;
  logic sec_lockdown = 1'b0;
  logic sec_allowlist = 1'b0;
  logic resp_valid;
  logic [2:0] resp_allow;
  logic resp_grant;

  logic [7:0] cfg_a [N];
  logic [REG_W-1:0] ar_a [N];
  int n_chk = 0;
  int n_bad = 0;

  // expected tables, {X,W,R}, indexed by {L,R,W,X}
  logic [2:0] tab_m [16] = '{0,0,3,3,0,0,0,0,0,4,4,5,1,5,3,1};
  logic [2:0] tab_u [16] = '{0,4,1,3,1,5,3,7,0,0,4,4,0,0,0,1};

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_bytes[i*8 +: 8] = cfg_a[i];
      addr_regs[i*REG_W +: REG_W] = ar_a[i];
    end
  end

  pmp_access_checker #(.N(N), .PA_W(PA_W), .SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_perm(req_perm), .req_mmode(req_mmode),
    .cfg_bytes(cfg_bytes), .addr_regs(addr_regs), .sec_lockdown(sec_lockdown),
    .sec_allowlist(sec_allowlist), .resp_valid(resp_valid),
    .resp_allow(resp_allow), .resp_grant(resp_grant));

  // model: returns {grant, allow}
  function automatic logic [3:0] model(input longint a, input int sz, input logic [2:0] p,
                                       input logic m);
    longint lst, lo, hi, rg;
    int k;
    logic inf, inl;
    logic [2:0] al;
    lst = a + ((sz == 0) ? 4 : sz) - 1;
    for (int i = 0; i < N; i++) begin
      rg = longint'(ar_a[i]);
      case (cfg_a[i][4:3])
        2'd1: begin lo = (i == 0) ? 0 : longint'(ar_a[i-1]) * 4; hi = rg * 4; end
        2'd2: begin lo = rg * 4; hi = lo + 4; end
        2'd3: begin
          k = 0;
          while (k < REG_W && rg[k]) k++;
          lo = (rg * 4) & ~((longint'(1) << (k + 3)) - 1);
          hi = lo + (longint'(1) << (k + 3));
        end
        default: begin lo = 0; hi = 0; end
      endcase
      if (cfg_a[i][4:3] != 2'd0) begin
        inf = (a >= lo) && (a < hi);
        inl = (lst >= lo) && (lst < hi);
        if (inf != inl) return 4'b0000;
        if (inf) begin
          if (!sec_lockdown) al = (m && !cfg_a[i][7]) ? 3'b111 : cfg_a[i][2:0];
          else if (m) al = tab_m[{cfg_a[i][7], cfg_a[i][0], cfg_a[i][1], cfg_a[i][2]}];
          else        al = tab_u[{cfg_a[i][7], cfg_a[i][0], cfg_a[i][1], cfg_a[i][2]}];
          return {((p & ~al) == 3'b000), al};
        end
      end
    end
    if (sec_allowlist) return 4'b0000;
    if (sec_lockdown) return (m && !p[2]) ? 4'b1011 : 4'b0000;
    return m ? 4'b1111 : 4'b0000;
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got grant=%0b allow=%0d, expected grant=%0b allow=%0d",
               tag, got[3], got[2:0], exp[3], exp[2:0]);
    end
  endtask

  task automatic run(input string tag, input longint a, input int sz, input logic [2:0] p,
                     input logic m);
    logic [3:0] exp;
    @(negedge clk);
    req_addr = PA_W'(a); req_size = SIZE_W'(sz); req_perm = p; req_mmode = m;
    req_valid = 1'b1;
    exp = model(a, sz, p, m);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " (R12 valid)"}, {3'b000, resp_valid}, 4'b0001);
    check(tag, {resp_grant, resp_allow}, exp);
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < N; i++) begin cfg_a[i] = 8'h00; ar_a[i] = '0; end
    sec_lockdown = 1'b0; sec_allowlist = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] held;
    int sizes [5] = '{0, 1, 2, 4, 8};
    void'($urandom(32'd7341));
    clear_cfg();
    repeat (3) @(negedge clk);
    check("R12 reset", {resp_grant, resp_allow}, 4'b0000);
    check("R12 reset valid", {3'b000, resp_valid}, 4'b0000);
    rst = 1'b0;

    // R10 fallback policies, no entries on
    run("R10 classic machine", 64'h100, 4, 3'b111, 1'b1);
    check("R10 classic machine expect", {resp_grant, resp_allow}, 4'b1111);
    run("R10 classic lower", 64'h100, 4, 3'b001, 1'b0);
    sec_lockdown = 1'b1;
    run("R10 lockdown machine read", 64'h100, 4, 3'b011, 1'b1);
    check("R10 lockdown RW expect", {resp_grant, resp_allow}, 4'b1011);
    run("R10 lockdown machine exec", 64'h100, 4, 3'b100, 1'b1);
    sec_allowlist = 1'b1;
    run("R10 allowlist", 64'h100, 4, 3'b001, 1'b1);
    check("R10 allowlist expect", {resp_grant, resp_allow}, 4'b0000);

    // R12 hold without strobe
    held = {resp_grant, resp_allow};
    @(negedge clk); @(negedge clk);
    check("R12 hold", {resp_grant, resp_allow}, held);
    check("R12 idle valid", {3'b000, resp_valid}, 4'b0000);

    // R2 four-byte region
    clear_cfg();
    cfg_a[0] = 8'h11; ar_a[0] = 32'h10;
    run("R2 inside", 64'h40, 4, 3'b001, 1'b0);
    check("R2 inside expect", {resp_grant, resp_allow}, 4'b1001);
    run("R2 just past", 64'h44, 4, 3'b001, 1'b0);
    // R11 size zero means 4 bytes
    run("R11 size0 full", 64'h40, 0, 3'b001, 1'b0);
    check("R11 size0 full expect", {resp_grant, resp_allow}, 4'b1001);
    run("R11 size0 partial", 64'h41, 0, 3'b001, 1'b0);
    check("R11 size0 partial expect", {resp_grant, resp_allow}, 4'b0000);
    run("R11 size1 last byte", 64'h43, 1, 3'b001, 1'b0);
    // R5 partial stops scan even with a later full cover
    cfg_a[1] = 8'h1F; ar_a[1] = 32'h0F;   // napot 0x00..0x7F RWX
    run("R5 partial", 64'h42, 4, 3'b001, 1'b0);
    check("R5 partial expect", {resp_grant, resp_allow}, 4'b0000);
    // R4 priority
    run("R4 lower index wins", 64'h40, 4, 3'b010, 1'b0);
    check("R4 expect", {resp_grant, resp_allow}, 4'b0001);
    cfg_a[0] = 8'h01;
    run("R4 off skipped", 64'h40, 4, 3'b010, 1'b0);
    check("R4 off expect", {resp_grant, resp_allow}, 4'b1111);

    // R3 power-of-two region 0x80..0x9F
    clear_cfg();
    cfg_a[2] = 8'h19; ar_a[2] = 32'h23;
    run("R3 top word", 64'h9C, 4, 3'b001, 1'b0);
    check("R3 top expect", {resp_grant, resp_allow}, 4'b1001);
    run("R3 base", 64'h80, 8, 3'b001, 1'b0);
    run("R3 beyond", 64'hA0, 4, 3'b001, 1'b0);
    check("R3 beyond expect", {resp_grant, resp_allow}, 4'b0000);

    // R1 top-of-range
    clear_cfg();
    ar_a[0] = 32'h10; cfg_a[1] = 8'h0B; ar_a[1] = 32'h20;
    run("R1 last word", 64'h7C, 4, 3'b011, 1'b0);
    check("R1 last expect", {resp_grant, resp_allow}, 4'b1011);
    run("R1 below", 64'h3C, 4, 3'b001, 1'b0);
    ar_a[1] = 32'h08;
    run("R1 inverted empty", 64'h20, 4, 3'b001, 1'b1);
    check("R1 inverted expect", {resp_grant, resp_allow}, 4'b1111);
    clear_cfg();
    cfg_a[0] = 8'h0F; ar_a[0] = 32'h00;
    run("R1 entry0 zero empty", 64'h0, 4, 3'b001, 1'b0);
    check("R1 entry0 expect", {resp_grant, resp_allow}, 4'b0000);

    // R6 classic lock effect in machine mode
    clear_cfg();
    cfg_a[0] = 8'h11; ar_a[0] = 32'h10;
    run("R6 unlocked machine", 64'h40, 4, 3'b110, 1'b1);
    check("R6 unlocked expect", {resp_grant, resp_allow}, 4'b1111);
    cfg_a[0] = 8'h91;
    run("R6 locked machine", 64'h40, 4, 3'b010, 1'b1);
    check("R6 locked expect", {resp_grant, resp_allow}, 4'b0001);

    // R7 / R8 full table sweeps
    sec_lockdown = 1'b1;
    for (int ix = 0; ix < 16; ix++) begin
      cfg_a[0] = {ix[3], 2'b00, 2'b10, ix[0], ix[1], ix[2]};
      run("R7 machine table", 64'h40, 4, 3'b000, 1'b1);
      check("R7 table value", {resp_grant, resp_allow}, {1'b1, tab_m[ix]});
      run("R8 lower table", 64'h40, 4, 3'b000, 1'b0);
      check("R8 table value", {resp_grant, resp_allow}, {1'b1, tab_u[ix]});
    end
    // R9 grant needs all requested bits
    cfg_a[0] = 8'h13;  // idx 6 lower -> RW
    run("R9 subset granted", 64'h40, 4, 3'b011, 1'b0);
    check("R9 subset expect", {resp_grant, resp_allow}, 4'b1011);
    run("R9 extra bit denied", 64'h40, 4, 3'b101, 1'b0);
    check("R9 extra expect", {resp_grant, resp_allow}, 4'b0011);

    // random mix against the model (R1..R11)
    for (int t = 0; t < 600; t++) begin
      for (int i = 0; i < N; i++) begin
        cfg_a[i] = 8'($urandom) & 8'h9F;
        if (($urandom % 3) == 0) cfg_a[i][4:3] = 2'b00;
        ar_a[i] = REG_W'($urandom % 80);
      end
      sec_lockdown = 1'($urandom);
      sec_allowlist = (($urandom % 4) == 0);
      run("R4 random", longint'($urandom % 340), sizes[$urandom % 5],
          3'($urandom), 1'($urandom));
    end

    finish_run();
  end
endmodule